// File: doc/BRIEF.md
# Pipelined Read Port for an External Processor Bus

This block is the device side of a read-only slave port on an external, memory-style processor bus. It runs entirely on the clock that the processor supplies. Two active-low chip selects are each paired with their own qualifier. Select term 1 needs its output-enable strobe low. Select term 0 needs its separate qualifier high. When either term is true, the block pops one word per clock from a show-ahead read FIFO and drives that word onto a 32-bit tri-state data bus.

The strobes are captured in an input register. The drive enable and the read data then travel through matching pipelines, `PIPE_DEPTH` stages long (1 to 4). The last stage of each pipeline is the register that faces the pin. Data and enable stay cycle-aligned, and the processor's read latency is set to cover the fixed delay. The FIFO shows its head word on `fifoData` whenever `fifoEmpty` is low, and it advances on `fifoPop`.

Top module: `busrd_port`

## Requirements
- R1: While `rstN` is low, `busDrive`, `fifoPop` and `underflow` are 0 and the bus is released.
- R2: Select term 1 (`csN[1]`=0 and `oeN`=0) at a sampling edge makes the bus drive.
- R3: Select term 0 (`csN[0]`=0 and `selQual`=1) at a sampling edge makes the bus drive.
- R4: No drive and no pop occur when the qualifiers are wrong (`csN[1]`=0 with `oeN`=1, or `csN[0]`=0 with `selQual`=0) or when both selects are high (`csN`=2'b11).
- R5: `busDrive` goes high right after the `PIPE_DEPTH`-th rising edge that follows the edge sampling a true select. It goes low with the same delay, and the bus is high impedance whenever `busDrive` is 0.
- R6: `fifoPop` is high for exactly one clock, right after each edge that sampled a true select, provided `fifoEmpty` is low.
- R7: While `busDrive` is high, `busData` carries the popped words in pop order, one per clock.
- R8: A true select while the FIFO is empty pops nothing and drives the last popped word again. It also sets `underflow`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Clock supplied by the processor |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 2 | Active-low chip selects |
| oeN | input | 1 | Active-low output enable, qualifies select 1 |
| selQual | input | 1 | Active-high qualifier for select 0 |
| fifoData | input | DATA_W | Head word of the read FIFO |
| fifoEmpty | input | 1 | Read FIFO has no word |
| fifoPop | output | 1 | Advance the read FIFO |
| busData | inout | DATA_W | Tri-state data bus |
| busDrive | output | 1 | Registered bus drive enable |
| underflow | output | 1 | Sticky flag for a read from an empty FIFO |

## Verification
The hardest case is a burst that runs past the end of the FIFO contents. The select must still stay true, the output must repeat the last word, and the sticky flag must survive a later good read. The stimulus loads a short run of words and holds select term 1 for more clocks than there are words. It then refills the FIFO and reads again. A cycle model of both pipelines predicts every drive edge, every pop and every data word.

// File: rtl/busrd_pkg.sv
package busrd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // decoded select sampled this cycle
    logic pop;    // FIFO advances this cycle
    logic drive;  // pin-side drive enable
  } rdStrobe_t;
endpackage

// File: rtl/busrd_ctrl.sv
module busrd_ctrl
  import busrd_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic       busClk,
  input  logic       rstN,
  input  logic [1:0] csN,
  input  logic       oeN,
  input  logic       selQual,
  input  logic       fifoEmpty,
  output rdStrobe_t  strb,
  output logic       underflow
);
  localparam int CNT_W = $clog2(PIPE_DEPTH + 2) + 1;

  logic [1:0] csReg;
  logic       oeReg;
  logic       qualReg;
  logic       selNow;
  logic [PIPE_DEPTH-1:0] enPipe;
  logic [CNT_W-1:0] sinceRst;

  // input register at the pin boundary
  always_ff @(posedge busClk) begin
    if (!rstN) begin
      csReg   <= 2'b11;
      oeReg   <= 1'b1;
      qualReg <= 1'b0;
    end else begin
      csReg   <= csN;
      oeReg   <= oeN;
      qualReg <= selQual;
    end
  end

  assign selNow = (!csReg[1] && !oeReg) || (!csReg[0] && qualReg);

  // enable pipeline, last stage faces the pin
  always_ff @(posedge busClk) begin
    if (!rstN) begin
      enPipe <= '0;
    end else begin
      enPipe[0] <= selNow;
      for (int i = 1; i < PIPE_DEPTH; i++) enPipe[i] <= enPipe[i-1];
    end
  end

  always_ff @(posedge busClk) begin
    if (!rstN) underflow <= 1'b0;
    else if (selNow && fifoEmpty) underflow <= 1'b1;
  end

  always_ff @(posedge busClk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst <= CNT_W'(PIPE_DEPTH)) sinceRst <= sinceRst + 1'b1;
  end

  assign strb.load  = selNow;
  assign strb.pop   = selNow && !fifoEmpty;
  assign strb.drive = enPipe[PIPE_DEPTH-1];

  initial begin
    depth_range_chk: assert (PIPE_DEPTH >= 1 && PIPE_DEPTH <= 4);
  end

  // R6
  pop_follows_select_chk: assert property (@(posedge busClk) disable iff (!rstN)
    strb.pop |-> $past((!csN[1] && !oeN) || (!csN[0] && selQual)));

  // R8
  underflow_sticky_chk: assert property (@(posedge busClk) disable iff (!rstN)
    underflow |=> underflow);

  // R8
  underflow_cause_chk: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(underflow) |-> $past(fifoEmpty));

  // R5
  drive_latency_chk: assert property (@(posedge busClk) disable iff (!rstN)
    (sinceRst > CNT_W'(PIPE_DEPTH)) |->
      (strb.drive == $past((!csN[1] && !oeN) || (!csN[0] && selQual), PIPE_DEPTH + 1)));
endmodule

// File: rtl/busrd_datapath.sv
module busrd_datapath
  import busrd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PIPE_DEPTH = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [DATA_W-1:0] fifoData,
  output logic [DATA_W-1:0] pinData
);
  logic [DATA_W-1:0] lastWord;
  logic [DATA_W-1:0] stage [PIPE_DEPTH];

  always_ff @(posedge busClk) begin
    if (!rstN) lastWord <= '0;
    else if (strb.pop) lastWord <= fifoData;
  end

  always_ff @(posedge busClk) begin
    if (!rstN) stage[0] <= '0;
    else if (strb.load) stage[0] <= strb.pop ? fifoData : lastWord;
  end

  genvar g;
  generate
    for (g = 1; g < PIPE_DEPTH; g++) begin : gStage
      always_ff @(posedge busClk) begin
        if (!rstN) stage[g] <= '0;
        else stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign pinData = stage[PIPE_DEPTH-1];

  // R8
  repeat_last_chk: assert property (@(posedge busClk) disable iff (!rstN)
    (strb.load && !strb.pop) |=> (stage[0] == $past(lastWord)));

  // R7
  pop_capture_chk: assert property (@(posedge busClk) disable iff (!rstN)
    strb.pop |=> (stage[0] == $past(fifoData)));
endmodule

// File: rtl/busrd_port.sv
module busrd_port
  import busrd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PIPE_DEPTH = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic [1:0]        csN,
  input  logic              oeN,
  input  logic              selQual,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoPop,
  inout  wire  [DATA_W-1:0] busData,
  output logic              busDrive,
  output logic              underflow
);
  rdStrobe_t         strb;
  logic [DATA_W-1:0] pinData;

  busrd_ctrl #(.PIPE_DEPTH(PIPE_DEPTH)) u_ctrl (
    .busClk(busClk), .rstN(rstN), .csN(csN), .oeN(oeN), .selQual(selQual),
    .fifoEmpty(fifoEmpty), .strb(strb), .underflow(underflow)
  );

  busrd_datapath #(.DATA_W(DATA_W), .PIPE_DEPTH(PIPE_DEPTH)) u_dp (
    .busClk(busClk), .rstN(rstN), .strb(strb), .fifoData(fifoData), .pinData(pinData)
  );

  assign fifoPop  = strb.pop;
  assign busDrive = strb.drive;
  assign busData  = strb.drive ? pinData : {DATA_W{1'bz}};
endmodule

// File: tb/busrd_port_tb.sv
`timescale 1ns/100ps
module busrd_port_tb;
  localparam int DW    = 32;
  localparam int DEPTH = 2;

  logic busClk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] csN = 2'b11;
  logic oeN = 1'b1;
  logic selQual = 1'b0;
  logic [DW-1:0] fifoData;
  logic fifoEmpty;
  logic fifoPop, busDrive, underflow;
  wire  [DW-1:0] busData;

  always #2.5 busClk = ~busClk;

  busrd_port #(.DATA_W(DW), .PIPE_DEPTH(DEPTH)) u_dut (
    .busClk(busClk), .rstN(rstN), .csN(csN), .oeN(oeN), .selQual(selQual),
    .fifoData(fifoData), .fifoEmpty(fifoEmpty), .fifoPop(fifoPop),
    .busData(busData), .busDrive(busDrive), .underflow(underflow)
  );

  // FIFO model
  logic [DW-1:0] mem [64];
  int head = 0;
  int tail = 0;
  assign fifoData  = mem[head % 64];
  assign fifoEmpty = (head == tail);

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;
  string curReq = "R1";

  // reference model
  bit selCap = 1'b0;
  bit eh [DEPTH];
  bit expUnder = 1'b0;
  logic [DW-1:0] lastW = '0;
  logic [DW-1:0] scoreQ [$];

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge busClk) begin
    if (!rstN) begin
      head <= 0;
      selCap = 1'b0;
      for (int i = 0; i < DEPTH; i++) eh[i] = 1'b0;
      expUnder = 1'b0;
      lastW = '0;
      scoreQ.delete();
    end else begin
      if (fifoPop) head <= head + 1;
      if (selCap) begin
        if (head != tail) lastW = mem[head % 64];
        else expUnder = 1'b1;
        scoreQ.push_back(lastW);
      end
      for (int i = DEPTH - 1; i > 0; i--) eh[i] = eh[i-1];
      eh[0] = selCap;
      selCap = (!csN[1] && !oeN) || (!csN[0] && selQual);
    end
  end

  // monitor
  always @(negedge busClk) begin
    if (monOn && rstN) begin
      chk(busDrive == eh[DEPTH-1], curReq, {31'b0, busDrive}, {31'b0, eh[DEPTH-1]});
      chk(fifoPop == (selCap && head != tail), "R6", {31'b0, fifoPop},
          {31'b0, selCap && head != tail});
      chk(underflow == expUnder, "R8", {31'b0, underflow}, {31'b0, expUnder});
      if (busDrive && eh[DEPTH-1]) begin
        if (scoreQ.size() == 0) chk(1'b0, "R7", busData, '0);
        else begin
          logic [DW-1:0] e;
          e = scoreQ.pop_front();
          chk(busData == e, "R7", busData, e);
        end
      end
    end
  end

  task automatic loadFifo(int n, logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      mem[tail % 64] = base + DW'(i);
      tail++;
    end
  endtask

  task automatic strobe(logic [1:0] cs, logic oe, logic q, int cyc, string req);
    @(negedge busClk);
    curReq = req;
    csN = cs; oeN = oe; selQual = q;
    repeat (cyc) @(negedge busClk);
    csN = 2'b11; oeN = 1'b1; selQual = 1'b0;
  endtask

  task automatic idle(int cyc);
    repeat (cyc) @(negedge busClk);
  endtask

  initial begin
    repeat (3) @(negedge busClk);
    // R1 reset state
    chk(busDrive == 1'b0, "R1", {31'b0, busDrive}, '0);
    chk(fifoPop == 1'b0, "R1", {31'b0, fifoPop}, '0);
    chk(underflow == 1'b0, "R1", {31'b0, underflow}, '0);
    rstN = 1'b1;
    monOn = 1'b1;
    loadFifo(6, 32'hA000_0010);
    // R2 burst via term 1
    strobe(2'b01, 1'b0, 1'b0, 3, "R2");
    idle(5);
    // R3 burst via term 0
    strobe(2'b10, 1'b1, 1'b1, 2, "R3");
    idle(5);
    // R4 wrong qualifiers: nothing drives, no pop
    strobe(2'b01, 1'b1, 1'b1, 2, "R4");
    strobe(2'b10, 1'b0, 1'b0, 2, "R4");
    strobe(2'b11, 1'b0, 1'b1, 2, "R4");
    idle(4);
    chk(busDrive == 1'b0, "R4", {31'b0, busDrive}, '0);
    chk(head == 5, "R4", DW'(head), DW'(5));
    // R5 single-cycle pulse latency
    strobe(2'b10, 1'b1, 1'b1, 1, "R5");
    idle(DEPTH);
    chk(busDrive == 1'b1, "R5", {31'b0, busDrive}, 32'd1);
    idle(1);
    chk(busDrive == 1'b0, "R5", {31'b0, busDrive}, '0);
    idle(3);
    // R8 run past the end of the FIFO
    loadFifo(2, 32'hB000_0100);
    strobe(2'b01, 1'b0, 1'b0, 5, "R8");
    idle(5);
    chk(underflow == 1'b1, "R8", {31'b0, underflow}, 32'd1);
    // refill after underflow: flag stays, data correct
    loadFifo(3, 32'hC000_0200);
    strobe(2'b10, 1'b1, 1'b1, 3, "R7");
    idle(6);
    chk(underflow == 1'b1, "R8", {31'b0, underflow}, 32'd1);
    chk(scoreQ.size() == 0, "R7", DW'(scoreQ.size()), '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge busClk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule